// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block controls a direct-mapped cache whose line array is treated as two halves, so that a pair of conflicting blocks can both stay resident at the cost of a slower second probe. Each address has a home line chosen by its index bits and a partner line in the opposite half, reached by inverting the top index bit. A request is first checked against the home line with a single tag compare. If that compare fails, the partner line is checked one cycle later, and a match there is a slower "pseudo-hit". Only when both lines fail does the block fetch the word from the next memory level.

The lines are kept ordered by recency. After a pseudo-hit the two lines trade places, so a repeated access becomes a fast hit. A refilled word is always placed at the home line, and the word it displaces moves to the partner line. Each response carries a two-bit code that says where the data came from. The CPU side uses a valid/ready request and a single-cycle response pulse. The next-level side uses a single-cycle request pulse and a single-cycle data return.

Top module: `psa_cache_ctrl`

## Requirements
- R1: The array has 2^INDEX_W one-word lines. The home index of an address is addr[INDEX_W-1:0]. The partner index is the home index with bit INDEX_W-1 inverted. The stored tag is addr[ADDR_W-1:INDEX_W-1], so each line identifies its block whichever half holds it.
- R2: After reset every line is invalid, req_ready is high, and resp_valid and mem_req_valid are low. The first access to any address is served as a refill.
- R3: When the home line matches, resp_valid is high in the cycle after the request is accepted, with resp_kind = 0 (fast) and the stored word on resp_data.
- R4: When only the partner line matches, resp_valid is high two cycles after acceptance, with resp_kind = 1 (pseudo) and the stored word. No next-level request is made.
- R5: When neither line matches, mem_req_valid pulses for exactly one cycle, two cycles after acceptance, with mem_req_addr equal to the request address. resp_valid follows in the cycle after mem_rsp_valid is sampled, with resp_kind = 2 (refill) and resp_data equal to mem_rsp_data.
- R6: A pseudo-hit swaps the two lines. The next access to the same address is a fast hit, and the block that held the home line becomes a pseudo-hit.
- R7: A refill writes the new word to the home line and moves the previous home line to the partner line. The previous partner line is dropped, so its next access is a refill.
- R8: req_ready is low from the cycle after a failed home probe until the response cycle, and high in the response cycle.
- R9: mem_rsp_valid is ignored while no refill is pending. It produces no response and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| resp_valid | output | 1 | Single-cycle response pulse |
| resp_data | output | DATA_W | Returned word |
| resp_kind | output | 2 | 0 fast hit, 1 pseudo-hit, 2 refill |
| mem_req_valid | output | 1 | Single-cycle next-level read request |
| mem_req_addr | output | ADDR_W | Address of the next-level read |
| mem_rsp_valid | input | 1 | Next-level data valid |
| mem_rsp_data | input | DATA_W | Next-level data |

## Verification
The bench runs a directed sequence over two blocks that share a home line and one block whose home line is the partner of theirs. The sequence makes the same address appear in turn as a cold miss, a fast hit, a pseudo-hit and a refill after eviction. Measured latency and the kind code separate a home-line match from a partner-line match and from a next-level fetch. Counting next-level pulses separates a pseudo-hit from a refill. A three-block chain on one line pair shows the difference between moving a line and dropping one. A stray next-level return injected while idle, followed by a hit, shows that the lines were left untouched.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [1:0] {
    KIND_FAST   = 2'd0,
    KIND_PSEUDO = 2'd1,
    KIND_REFILL = 2'd2
  } psa_kind_e;
endpackage

// File: rtl/psa_tag_match.sv
module psa_tag_match #(
  parameter int TAG_W = 13
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit
);
  assign hit = line_valid && (line_tag == want_tag);
endmodule

// File: rtl/psa_line_store.sv
module psa_line_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 13,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INDEX_W-1:0] home_idx,
  output logic              h_valid,
  output logic [TAG_W-1:0]  h_tag,
  output logic [DATA_W-1:0] h_data,
  output logic              p_valid,
  output logic [TAG_W-1:0]  p_tag,
  output logic [DATA_W-1:0] p_data,
  input  logic              wr_en,
  input  logic              wr_h_valid,
  input  logic [TAG_W-1:0]  wr_h_tag,
  input  logic [DATA_W-1:0] wr_h_data,
  input  logic              wr_p_valid,
  input  logic [TAG_W-1:0]  wr_p_tag,
  input  logic [DATA_W-1:0] wr_p_data
);
  localparam int LINES = 1 << INDEX_W;
  localparam logic [INDEX_W-1:0] HALF_BIT = {1'b1, {(INDEX_W-1){1'b0}}};

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [INDEX_W-1:0] part_idx;

  // partner line sits in the other half
  assign part_idx = home_idx ^ HALF_BIT;

  assign h_valid = valid_q[home_idx];
  assign h_tag   = tag_q[home_idx];
  assign h_data  = data_q[home_idx];
  assign p_valid = valid_q[part_idx];
  assign p_tag   = tag_q[part_idx];
  assign p_data  = data_q[part_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[home_idx] <= wr_h_valid;
      valid_q[part_idx] <= wr_p_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[home_idx]  <= wr_h_tag;
      data_q[home_idx] <= wr_h_data;
      tag_q[part_idx]  <= wr_p_tag;
      data_q[part_idx] <= wr_p_data;
    end
  end
endmodule

// File: rtl/psa_cache_ctrl.sv
module psa_cache_ctrl
  import psa_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_kind,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int TAG_W = ADDR_W - INDEX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ALT, S_FILL} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [ADDR_W-1:0] look_addr;
  logic [INDEX_W-1:0] look_idx;
  logic [TAG_W-1:0]  look_tag;

  logic              h_valid, p_valid, h_hit, p_hit;
  logic [TAG_W-1:0]  h_tag, p_tag;
  logic [DATA_W-1:0] h_data, p_data;

  logic              wr_en, wr_h_valid, wr_p_valid;
  logic [TAG_W-1:0]  wr_h_tag, wr_p_tag;
  logic [DATA_W-1:0] wr_h_data, wr_p_data;

  assign req_ready = (state_q == S_IDLE);
  assign look_addr = (state_q == S_IDLE) ? req_addr : cur_addr_q;
  assign look_idx  = look_addr[INDEX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:INDEX_W-1];

  psa_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .home_idx(look_idx),
    .h_valid(h_valid), .h_tag(h_tag), .h_data(h_data),
    .p_valid(p_valid), .p_tag(p_tag), .p_data(p_data),
    .wr_en(wr_en),
    .wr_h_valid(wr_h_valid), .wr_h_tag(wr_h_tag), .wr_h_data(wr_h_data),
    .wr_p_valid(wr_p_valid), .wr_p_tag(wr_p_tag), .wr_p_data(wr_p_data)
  );

  psa_tag_match #(.TAG_W(TAG_W)) u_home_cmp (
    .line_valid(h_valid), .line_tag(h_tag), .want_tag(look_tag), .hit(h_hit)
  );
  psa_tag_match #(.TAG_W(TAG_W)) u_part_cmp (
    .line_valid(p_valid), .line_tag(p_tag), .want_tag(look_tag), .hit(p_hit)
  );

  // line movement: swap on partner hit, shift-in on refill
  always_comb begin
    wr_en      = 1'b0;
    wr_h_valid = p_valid;
    wr_h_tag   = p_tag;
    wr_h_data  = p_data;
    wr_p_valid = h_valid;
    wr_p_tag   = h_tag;
    wr_p_data  = h_data;
    if (state_q == S_ALT && p_hit) begin
      wr_en = 1'b1;
    end else if (state_q == S_FILL && mem_rsp_valid) begin
      wr_en      = 1'b1;
      wr_h_valid = 1'b1;
      wr_h_tag   = look_tag;
      wr_h_data  = mem_rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      cur_addr_q    <= '0;
      resp_valid    <= 1'b0;
      resp_data     <= '0;
      resp_kind     <= KIND_FAST;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          cur_addr_q <= req_addr;
          if (h_hit) begin
            resp_valid <= 1'b1;
            resp_data  <= h_data;
            resp_kind  <= KIND_FAST;
          end else begin
            state_q <= S_ALT;
          end
        end
        S_ALT: begin
          if (p_hit) begin
            resp_valid <= 1'b1;
            resp_data  <= p_data;
            resp_kind  <= KIND_PSEUDO;
            state_q    <= S_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= cur_addr_q;
            state_q       <= S_FILL;
          end
        end
        S_FILL: if (mem_rsp_valid) begin
          resp_valid <= 1'b1;
          resp_data  <= mem_rsp_data;
          resp_kind  <= KIND_REFILL;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && h_hit) |=> (resp_valid && resp_kind == KIND_FAST)); // R3
  AST_PSEUDO_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ALT && p_hit) |=> (resp_valid && resp_kind == KIND_PSEUDO && !mem_req_valid)); // R4
  AST_REFILL_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_kind == KIND_REFILL) |-> $past(mem_rsp_valid)); // R5
  AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && state_q == S_IDLE && !req_valid) |=> !resp_valid); // R9
endmodule

// File: tb/tb_psa_cache_ctrl.sv
`timescale 1ns/1ps
module tb_psa_cache_ctrl;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int K_FAST = 0, K_PSEUDO = 1, K_REFILL = 2;
  localparam int REFILL_LAT = 5;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic resp_valid;
  logic [DATA_W-1:0] resp_data;
  logic [1:0] resp_kind;
  logic mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;
  int stray_cnt = 0;
  int stray_done = 0;

  always #2 clk = ~clk;

  psa_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(4)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_kind(resp_kind), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next-level model: answers two cycles after seeing a request
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [ADDR_W-1:0] a;
        a = mem_req_addr;
        repeat (2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else if (stray_cnt != stray_done) begin
        stray_done++;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_access(input logic [ADDR_W-1:0] a, input int ek, input string req);
    int lat;
    int reqs;
    bit got;
    int elat;
    logic [ADDR_W-1:0] seen;
    lat = 0; reqs = 0; got = 1'b0; seen = '0;
    elat = (ek == K_FAST) ? 1 : (ek == K_PSEUDO) ? 2 : REFILL_LAT;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    while (!got && lat < 40) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (mem_req_valid) begin
        reqs++;
        seen = mem_req_addr;
      end
      if (resp_valid) got = 1'b1;
      else chk(req_ready == 1'b0, "R8", "ready low while busy", req_ready, 0);
    end
    chk(got, req, "response seen", got, 1);
    chk(lat == elat, req, "latency", lat, elat);
    chk(resp_kind == ek[1:0], req, "kind", resp_kind, ek);
    chk(resp_data == mem_word(a), req, "data", resp_data, mem_word(a));
    chk(req_ready == 1'b1, "R8", "ready in response cycle", req_ready, 1);
    chk(reqs == ((ek == K_REFILL) ? 1 : 0), (ek == K_REFILL) ? "R5" : "R4",
        "next-level pulses", reqs, (ek == K_REFILL) ? 1 : 0);
    if (ek == K_REFILL) chk(seen == a, "R5", "next-level address", seen, a);
  endtask

  task automatic t_reset_state();
    chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R2", "resp idle after reset", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R2", "mem idle after reset", mem_req_valid, 0);
  endtask

  task automatic t_stray_return();
    stray_cnt++;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(resp_valid == 1'b0, "R9", "no response to stray return", resp_valid, 0);
    end
  endtask

  // block addresses: A and C share home line 2; B's home is line 10 (partner of 2)
  localparam logic [ADDR_W-1:0] A = 16'h0012;
  localparam logic [ADDR_W-1:0] B = 16'h001A;
  localparam logic [ADDR_W-1:0] C = 16'h0022;
  localparam logic [ADDR_W-1:0] D = 16'h0035;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset_state();                   // R2
    do_access(A, K_REFILL, "R2");      // cold miss
    do_access(A, K_FAST,   "R3");
    do_access(C, K_REFILL, "R7");      // A moves to line 10
    do_access(A, K_PSEUDO, "R4");      // swap: A home, C partner
    do_access(A, K_FAST,   "R6");
    do_access(C, K_PSEUDO, "R6");      // swap back: C home, A partner
    do_access(B, K_REFILL, "R1");      // B home 10, partner 2 holds C
    do_access(C, K_REFILL, "R7");      // C was dropped by B's refill
    do_access(A, K_PSEUDO, "R1");      // A sits in line 10 again
    t_stray_return();
    do_access(A, K_FAST,   "R9");      // line intact after stray
    do_access(D, K_REFILL, "R5");
    do_access(D, K_FAST,   "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule